// File: doc/BRIEF.md
# XOR-Encoding Crossbar Output Port

This block is one output port of a five-port wormhole mesh router. Each input whose flit targets this output presents it at once, with no wait for arbitration. The port XORs every presented flit onto the 64-bit link. A round-robin arbiter runs alongside and picks one contender per cycle. In the next cycle that contender is removed from the XOR set. When only one flit is left, it goes out unmodified. A receiver can therefore recover each flit by XORing two consecutive link words, and no link cycle is spent on a lost speculation.

The input side uses valid/ready. An input raises `in_valid` with its flit and keeps both stable until `in_ready` is high in the same cycle. `in_ready` is the grant, and the input's buffer pops in that cycle. The link has no back-pressure, because the downstream buffer always accepts. `out_enc` marks link words that carry an XOR of two or more flits.

A flit with `in_last` low opens a multi-flit packet. Only head flits are ever encoded. The body of such a packet follows on an exclusive path once the current collision has been fully sent.

Top module: `xop_out_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `out_enc` are 0. Reset clears the contender set, the reservations and the arbiter pointer, so the first grant after reset searches from input 0.
- R2: When exactly one flit is eligible in a cycle, one clock later `out_valid`=1, `out_data` equals that flit unchanged and `out_enc`=0.
- R3: When two or more flits are eligible in a cycle, one clock later `out_valid`=1, `out_data` is the bitwise XOR of all of them and `out_enc`=1.
- R4: In each cycle with at least one eligible flit, exactly one `in_ready` bit is high, combinationally. It belongs to the first eligible input at or after the pointer, counting upward and wrapping from 4 to 0. The pointer then moves to the winner's index plus one, modulo 5.
- R5: A collision starts a frozen contender set. In each following cycle the previous winner is removed and the remaining members are XORed, until a single member is sent raw. The link is valid on every cycle of the sequence; for winners A then B out of {A,B,C} it carries A^B^C, B^C, C.
- R6: While a collision sequence is in progress, inputs outside its frozen set get no `in_ready`, and their data is not part of `out_data`. This covers inputs that newly assert valid and new flits presented by inputs already granted.
- R7: Granting a flit with `in_last`=0 reserves the path for that input. After any running collision sequence ends, the lowest-index reserved input alone is eligible. Its flits go out raw until its flit with `in_last`=1 is granted, and other inputs get no `in_ready` meanwhile.
- R8: One clock after a cycle with no eligible flit, `out_valid` is 0.
- R9: `in_ready` is never high for an input whose `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Per input: a flit targeting this output is presented |
| in_data | input | 5x64 | Per input flit payload |
| in_last | input | 5 | Per input: flit is the final (or only) flit of its packet |
| in_ready | output | 5 | Per input grant; the input pops its flit in this cycle |
| out_valid | output | 1 | Link word valid |
| out_data | output | 64 | Link word: a raw flit or an XOR of flits |
| out_enc | output | 1 | Link word is an XOR of two or more flits |

## Verification
`in_ready` is combinational, so it is due in the same cycle the inputs are presented. The link outputs are registered and are due one rising edge after that cycle. The bench changes inputs only at falling edges. It reads `in_ready` 1 ns after driving, before the rising edge. It reads `out_valid`, `out_data` and `out_enc` at the next falling edge, so that each link check matches exactly the cycle whose inputs produced it. The pointer positions behind each expected grant are derived by hand from the order of the earlier scenarios.

// File: rtl/xop_pkg.sv
package xop_pkg;

  // Which rule selects the eligible inputs in the current cycle.
  typedef enum logic [1:0] {
    PH_OPEN   = 2'd0,  // any valid input may contend
    PH_ENCODE = 2'd1,  // a frozen collision set is being drained
    PH_HOLD   = 2'd2   // a reserved multi-flit packet owns the path
  } phase_e;

endpackage

// File: rtl/xop_rr_arb.sv
module xop_rr_arb #(
  parameter int N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REQ - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] win;
  logic             found;

  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N_REQ; k++) begin
      logic [IDX_W-1:0] j;
      j = IDX_W'((int'(ptr_q) + k) % N_REQ);
      if (!found && req[j]) begin
        found  = 1'b1;
        gnt[j] = 1'b1;
        win    = j;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= (win == LAST_IDX) ? '0 : win + 1'b1;
    end
  end

  // R4
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R4
  gnt_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0) && ((gnt & ~req) == '0));

endmodule

// File: rtl/xop_xor_fabric.sv
module xop_xor_fabric #(
  parameter int N_SRC  = 5,
  parameter int DATA_W = 64
) (
  input  logic [N_SRC-1:0]             sel,
  input  logic [N_SRC-1:0][DATA_W-1:0] src,
  output logic [DATA_W-1:0]            xo,
  output logic                         any
);
  always_comb begin
    xo = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel[i]) xo = xo ^ src[i];
    end
  end

  assign any = |sel;

endmodule

// File: rtl/xop_episode_ctrl.sv
module xop_episode_ctrl
  import xop_pkg::*;
#(
  parameter int N_IN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in_valid,
  input  logic [N_IN-1:0] in_last,
  input  logic [N_IN-1:0] gnt,
  output logic [N_IN-1:0] elig,
  output logic [N_IN-1:0] pend,
  output logic [N_IN-1:0] hold,
  output logic            multi
);
  localparam logic [N_IN-1:0] ONE = N_IN'(1);

  logic [N_IN-1:0] pend_q, hold_q;
  logic [N_IN-1:0] owner;
  phase_e          ph;

  assign owner = hold_q & (~hold_q + ONE);

  always_comb begin
    if (pend_q != '0)      ph = PH_ENCODE;
    else if (hold_q != '0) ph = PH_HOLD;
    else                   ph = PH_OPEN;
  end

  always_comb begin
    unique case (ph)
      PH_ENCODE: elig = pend_q & in_valid;
      PH_HOLD:   elig = owner & in_valid;
      default:   elig = in_valid;
    endcase
  end

  assign multi = ($countones(elig) > 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      hold_q <= '0;
    end else begin
      pend_q <= multi ? (elig & ~gnt) : '0;
      hold_q <= (hold_q & ~(gnt & in_last)) | (gnt & ~in_last);
    end
  end

  assign pend = pend_q;
  assign hold = hold_q;

  // R6
  frozen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) != '0) |-> ((pend_q & ~$past(pend_q)) == '0));

  // R5
  winner_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> ((pend_q & $past(gnt)) == '0));

endmodule

// File: rtl/xop_out_port.sv
module xop_out_port #(
  parameter int N_IN   = 5,
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IN-1:0]             in_valid,
  input  logic [N_IN-1:0][DATA_W-1:0] in_data,
  input  logic [N_IN-1:0]             in_last,
  output logic [N_IN-1:0]             in_ready,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_enc
);
  logic [N_IN-1:0]   elig, gnt, pend, hold;
  logic              multi, any;
  logic [DATA_W-1:0] xo;

  xop_episode_ctrl #(.N_IN(N_IN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .gnt(gnt), .elig(elig), .pend(pend), .hold(hold), .multi(multi)
  );

  xop_rr_arb #(.N_REQ(N_IN)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(elig), .gnt(gnt)
  );

  xop_xor_fabric #(.N_SRC(N_IN), .DATA_W(DATA_W)) fab_i (
    .sel(elig), .src(in_data), .xo(xo), .any(any)
  );

  assign in_ready = gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_enc   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= any;
      out_enc   <= multi;
      out_data  <= xo;
    end
  end

  // R9
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  // R3
  enc_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_enc |-> out_valid);

  // R5
  no_gap_after_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_enc |=> out_valid);

  // R7
  hold_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend == '0) && (hold != '0)) |-> ((in_ready & ~hold) == '0));

endmodule

// File: tb/xop_out_port_tb_top.sv
`timescale 1ns/1ps
module xop_out_port_tb_top;
  localparam int N = 5;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]        vld, lst, rdy;
  logic [N-1:0][W-1:0] dat;
  logic                ov, oe;
  logic [W-1:0]        od;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  xop_out_port #(.N_IN(N), .DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(dat), .in_last(lst),
    .in_ready(rdy), .out_valid(ov), .out_data(od), .out_enc(oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Check the grant of the cycle being presented, then advance one clock.
  task automatic tick(input string tag, input logic [N-1:0] exp_rdy);
    #1;
    chk({tag, " ready"}, W'(rdy), W'(exp_rdy));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic outchk(input string tag, input bit v, input logic [W-1:0] d, input bit e);
    chk({tag, " out_valid"}, W'(ov), W'(v));
    if (v) chk({tag, " out_data"}, od, d);
    chk({tag, " out_enc"}, W'(oe), W'(e));
  endtask

  task automatic t_reset();
    vld = '0; lst = '0; dat = '0;
    repeat (3) @(negedge clk);
    outchk("R1 in reset", 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    tick("R1 first idle", '0);
    outchk("R1 after reset", 1'b0, '0, 1'b0);
  endtask

  task automatic t_single();
    dat[3] = 64'h0123_4567_89AB_CDEF; lst[3] = 1'b1; vld[3] = 1'b1;
    tick("R2 R4 sole from ptr0", 5'b01000);
    outchk("R2 sole raw", 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0);
    vld = '0;
    tick("R9 idle no ready", '0);
    outchk("R8 idle link", 1'b0, '0, 1'b0);
  endtask

  task automatic t_three();
    logic [W-1:0] a, b, c;
    a = 64'hAAAA_0000_1111_0001; b = 64'h0B0B_2222_0000_0002; c = 64'h00C0_3333_4444_0003;
    dat[0] = a; dat[1] = b; dat[2] = c; lst = '1; vld = 5'b00111;
    tick("R4 wrap to 0", 5'b00001);
    outchk("R3 A^B^C", 1'b1, a ^ b ^ c, 1'b1);
    vld[0] = 1'b0;
    tick("R4 next 1", 5'b00010);
    outchk("R5 B^C", 1'b1, b ^ c, 1'b1);
    vld[1] = 1'b0;
    tick("R5 last 2", 5'b00100);
    outchk("R5 C raw", 1'b1, c, 1'b0);
    vld = '0;
  endtask

  task automatic t_newcomer();
    logic [W-1:0] d1, d4, e4, d0;
    d1 = 64'h1111_1111_0000_0001; d4 = 64'h4444_0000_4444_0004;
    e4 = 64'hE4E4_E4E4_E4E4_E4E4; d0 = 64'h0D0D_0000_0000_00D0;
    lst = '1; dat[1] = d1; dat[4] = d4; vld = 5'b10010;
    tick("R4 ptr3 picks 4", 5'b10000);
    outchk("R3 D1^D4", 1'b1, d1 ^ d4, 1'b1);
    dat[4] = e4; dat[0] = d0; vld = 5'b10011;
    tick("R6 only member 1", 5'b00010);
    outchk("R6 D1 raw no newcomers", 1'b1, d1, 1'b0);
    vld[1] = 1'b0;
    tick("R4 ptr2 picks 4", 5'b10000);
    outchk("R3 D0^E4", 1'b1, d0 ^ e4, 1'b1);
    vld[4] = 1'b0;
    tick("R5 last 0", 5'b00001);
    outchk("R5 D0 raw", 1'b1, d0, 1'b0);
    vld = '0;
    tick("R9 idle", '0);
    outchk("R8 idle link", 1'b0, '0, 1'b0);
  endtask

  task automatic t_worm_collide();
    logic [W-1:0] h2, s3, b2, t2, x1;
    h2 = 64'h4EAD_0000_0000_0002; s3 = 64'h5151_0000_0000_0003;
    b2 = 64'hB0D7_0000_0000_0002; t2 = 64'h7A11_0000_0000_0002; x1 = 64'h0001_0001_0001_0001;
    dat[2] = h2; lst[2] = 1'b0; dat[3] = s3; lst[3] = 1'b1; vld = 5'b01100;
    tick("R7 head wins", 5'b00100);
    outchk("R3 H2^S3", 1'b1, h2 ^ s3, 1'b1);
    dat[2] = b2; dat[1] = x1; lst[1] = 1'b1; vld = 5'b01110;
    tick("R6 finish episode", 5'b01000);
    outchk("R5 S3 raw", 1'b1, s3, 1'b0);
    vld[3] = 1'b0;
    tick("R7 body exclusive", 5'b00100);
    outchk("R7 body raw", 1'b1, b2, 1'b0);
    dat[2] = t2; lst[2] = 1'b1;
    tick("R7 tail exclusive", 5'b00100);
    outchk("R7 tail raw", 1'b1, t2, 1'b0);
    vld[2] = 1'b0;
    tick("R7 released", 5'b00010);
    outchk("R7 waiting input out", 1'b1, x1, 1'b0);
    vld = '0;
  endtask

  task automatic t_worm_solo();
    logic [W-1:0] h0, t0, d4;
    h0 = 64'hF00D_0000_0000_0000; t0 = 64'hF00D_FFFF_0000_0000; d4 = 64'h0404_0404_0404_0404;
    dat[0] = h0; lst[0] = 1'b0; vld = 5'b00001;
    tick("R7 solo head", 5'b00001);
    outchk("R2 head raw", 1'b1, h0, 1'b0);
    dat[0] = t0; lst[0] = 1'b1; dat[4] = d4; lst[4] = 1'b1; vld = 5'b10001;
    tick("R7 blocks 4", 5'b00001);
    outchk("R7 tail raw", 1'b1, t0, 1'b0);
    vld[0] = 1'b0;
    tick("R7 then 4", 5'b10000);
    outchk("R2 D4 raw", 1'b1, d4, 1'b0);
    vld = '0;
  endtask

  task automatic t_five();
    logic [N-1:0] left;
    logic [W-1:0] x;
    lst = '1;
    for (int i = 0; i < N; i++) dat[i] = {32'(i + 1) * 32'h0101_0101, 32'hC0DE_0000 | 32'(i)};
    vld = '1;
    left = '1;
    for (int k = 0; k < N; k++) begin
      x = '0;
      for (int i = 0; i < N; i++) if (left[i]) x = x ^ dat[i];
      tick("R4 five-way order", N'(1) << k);
      outchk("R5 five-way link", 1'b1, x, (k < N - 1));
      left[k] = 1'b0;
      vld[k]  = 1'b0;
    end
    tick("R9 idle", '0);
    outchk("R8 idle link", 1'b0, '0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_three();
    t_newcomer();
    t_worm_collide();
    t_worm_solo();
    t_five();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule